// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs one processor bus transfer at a time on a shared 16-bit address/data path with wait states. A transfer request comes in on a valid/ready port with an address, write data, a two-bit space code and a write flag. The block then runs a fixed sequence. First it raises an address strobe for one clock with the address on the shared lines, and holds a word-aligned copy of that address on a latch output. Next it pulls the active-low transfer line low and either drives the write data or releases the lines for a read. While the transfer line is low, exactly one active-low command strobe is asserted. The strobe is chosen by the space code and the write flag.

The ready input is sampled on a falling clock edge one and a half clocks after the transfer line drops. The block acts on that sample at the following rising edge. A low sample adds one clock, and the line is sampled again one clock later. When the sample is high, read data is captured from the shared lines and a one-cycle response pulse is produced.

The request port follows these back-pressure rules. `req_ready` is high only while the controller is idle, owns the bus and no release is pending. A request is taken on any rising edge where both `req_valid` and `req_ready` are high. The request fields are copied at that edge, so they may change afterwards. The response port has no back-pressure: `rsp_valid` is a single-cycle pulse. A bus-release input lets another master take the bus between transfers. After a locked-memory read, release is refused until a locked-memory write has completed, so that a test-and-modify pair stays atomic.

Top module: `mbc_top`

## Requirements
- R1: After reset, `xfer_n` is high, `addr_stb` is low, `ad_oe` is low, all eight command strobes are high, `rsp_valid` is low, `req_ready` is high and `drv_en` is high.
- R2: In the clock after a request is accepted, `addr_stb` is high for exactly one cycle. During that cycle `ad_out` carries the accepted address, `ad_oe` is high, `xfer_n` is high and `req_ready` is low.
- R3: From the end of the address-strobe cycle until the next accepted transfer, `lat_addr` holds the accepted address with bit 0 forced to zero, regardless of later changes on the request port.
- R4: `xfer_n` goes low in the clock after the address-strobe cycle. For a write, `ad_oe` is high with `ad_out` carrying the write data. For a read, `ad_oe` is low.
- R5: `bus_ready` is sampled on the falling edge 1.5 clocks after `xfer_n` falls. If that sample is high, `xfer_n` is low for exactly two cycles.
- R6: Each low `bus_ready` sample adds one clock, and the line is sampled again one clock later. With W low samples, `xfer_n` stays low for 2+W cycles.
- R7: In the cycle after `xfer_n` returns high, `rsp_valid` is high for one cycle. For a read, `rsp_rdata` equals `ad_in` at the rising edge that ended the transfer.
- R8: While `xfer_n` is low, the asserted strobe is selected by the space code and the write flag. The space codes are: 00 locked memory, 01 memory, 10 I/O, 11 external register. The write flag selects the write strobe when 1 and the read strobe when 0.
- R9: At most one command strobe is low at any time, and none is low while `xfer_n` is high.
- R10: `req_ready` stays low from acceptance until the transfer completes. No second address strobe appears during a transfer.
- R11: A high `bus_release` while idle takes precedence over a request offered in the same cycle. `req_ready` drops at once, and from the next edge `drv_en` is low and no transfer starts. One clock after release drops, `drv_en` and `req_ready` return high, and a request then runs normally.
- R12: After a locked-memory read completes, `bus_release` is not honoured (`drv_en` stays high, requests are still accepted) until a locked-memory write completes. `drv_en` then falls on the edge after the write's completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request offered |
| req_ready | output | 1 | Request can be taken this edge |
| req_space | input | 2 | Space code (00 locked mem, 01 mem, 10 I/O, 11 ext reg) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data captured at completion |
| ad_out | output | 16 | Shared lines, outbound value |
| ad_oe | output | 1 | Shared lines driven when high |
| ad_in | input | 16 | Shared lines, inbound value |
| addr_stb | output | 1 | Address strobe, active high |
| xfer_n | output | 1 | Transfer in progress, active low |
| bus_ready | input | 1 | Device ready, high ends the transfer |
| lat_addr | output | 16 | Latched word-aligned address |
| bus_release | input | 1 | Another master wants the bus |
| drv_en | output | 1 | Enables the external drivers for strobes and address |
| lmem_rd_n | output | 1 | Locked memory read strobe |
| lmem_wr_n | output | 1 | Locked memory write strobe |
| mem_rd_n | output | 1 | Memory read strobe |
| mem_wr_n | output | 1 | Memory write strobe |
| io_rd_n | output | 1 | I/O read strobe |
| io_wr_n | output | 1 | I/O write strobe |
| xr_rd_n | output | 1 | External register read strobe |
| xr_wr_n | output | 1 | External register write strobe |

## Verification
Two functions can fall in the same idle cycle: a bus-release request and the acceptance of a pending transfer. The bench raises `bus_release` and `req_valid` together and requires that `req_ready` drops, that no address strobe follows and that `drv_en` falls. It also provokes the locked case, where release arrives while a locked read/write pair is open. There, the locked write must still be accepted, and the release must take effect only on the edge after that write's completion.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  typedef enum logic [1:0] {
    SP_LMEM = 2'b00,
    SP_MEM  = 2'b01,
    SP_IO   = 2'b10,
    SP_XREG = 2'b11
  } space_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_REQ1,
    ST_REQW
  } seq_e;

  typedef struct packed {
    space_e space;
    logic   write;
  } kind_t;

  localparam int KIND_W  = $bits(kind_t);
  localparam int NUM_CMD = 1 << KIND_W;
endpackage

// File: rtl/mbc_sequencer.sv
module mbc_sequencer (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic bus_release,
  input  logic lock_held,
  input  logic bus_ready,
  output logic req_ready,
  output logic accept,
  output logic addr_stb,
  output logic xfer_n,
  output logic done,
  output logic released
);
  import mbc_pkg::*;

  seq_e state;
  logic rdy_fall;
  logic release_now;

  // half-clock sampler: the rising-edge logic reads this value back
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rdy_fall <= 1'b0;
    else        rdy_fall <= bus_ready;
  end

  assign release_now = bus_release && !lock_held;
  assign req_ready   = (state == ST_IDLE) && !released && !release_now;
  assign accept      = req_valid && req_ready;
  assign addr_stb    = (state == ST_ADDR);
  assign xfer_n      = !((state == ST_REQ1) || (state == ST_REQW));
  assign done        = (state == ST_REQW) && rdy_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) state <= ST_ADDR;
        ST_ADDR: state <= ST_REQ1;
        ST_REQ1: state <= ST_REQW;
        ST_REQW: if (rdy_fall) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                released <= 1'b0;
    else if ((state == ST_IDLE) && release_now) released <= 1'b1;
    else if (!bus_release)                     released <= 1'b0;
  end

  // R2
  ast_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb |=> (!addr_stb && !xfer_n));
  // R5
  min_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_n) |=> !xfer_n);
  // R10
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_n || addr_stb) |-> !req_ready);
endmodule

// File: rtl/mbc_addr_latch.sv
module mbc_addr_latch #(
  parameter int BUS_W      = 16,
  parameter int ALIGN_BITS = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic               addr_stb,
  input  logic [BUS_W-1:0]   req_addr,
  input  logic [BUS_W-1:0]   req_wdata,
  input  mbc_pkg::kind_t     req_kind,
  output logic [BUS_W-1:0]   hold_addr,
  output logic [BUS_W-1:0]   hold_wdata,
  output mbc_pkg::kind_t     hold_kind,
  output logic [BUS_W-1:0]   lat_addr
);
  import mbc_pkg::*;

  logic [BUS_W-1:0] aligned;

  genvar b;
  generate
    for (b = 0; b < BUS_W; b++) begin : g_align
      if (b < ALIGN_BITS) begin : g_zero
        assign aligned[b] = 1'b0;
      end else begin : g_keep
        assign aligned[b] = hold_addr[b];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_addr  <= '0;
      hold_wdata <= '0;
      hold_kind  <= '{space: SP_LMEM, write: 1'b0};
    end else if (accept) begin
      hold_addr  <= req_addr;
      hold_wdata <= req_wdata;
      hold_kind  <= req_kind;
    end
  end

  // trailing edge of the address strobe captures the address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lat_addr <= '0;
    else if (addr_stb) lat_addr <= aligned;
  end

  // R3
  lat_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(addr_stb) |-> $stable(lat_addr));
endmodule

// File: rtl/mbc_cmd_decode.sv
module mbc_cmd_decode (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            active,
  input  mbc_pkg::kind_t                  kind,
  output logic [mbc_pkg::NUM_CMD-1:0]     cmd_n
);
  import mbc_pkg::*;

  logic [KIND_W-1:0] code;
  assign code = {kind.space, kind.write};

  genvar i;
  generate
    for (i = 0; i < NUM_CMD; i++) begin : g_cmd
      assign cmd_n[i] = !(active && (code == KIND_W'(i)));
    end
  endgenerate

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cmd_n));
  // R9
  strobe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (&cmd_n));
endmodule

// File: rtl/mbc_top.sv
module mbc_top #(
  parameter int BUS_W      = 16,
  parameter int ALIGN_BITS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_space,
  input  logic             req_write,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_wdata,
  output logic             rsp_valid,
  output logic [BUS_W-1:0] rsp_rdata,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe,
  input  logic [BUS_W-1:0] ad_in,
  output logic             addr_stb,
  output logic             xfer_n,
  input  logic             bus_ready,
  output logic [BUS_W-1:0] lat_addr,
  input  logic             bus_release,
  output logic             drv_en,
  output logic             lmem_rd_n,
  output logic             lmem_wr_n,
  output logic             mem_rd_n,
  output logic             mem_wr_n,
  output logic             io_rd_n,
  output logic             io_wr_n,
  output logic             xr_rd_n,
  output logic             xr_wr_n
);
  import mbc_pkg::*;

  kind_t             req_kind;
  kind_t             hold_kind;
  logic [BUS_W-1:0]  hold_addr;
  logic [BUS_W-1:0]  hold_wdata;
  logic              accept;
  logic              done;
  logic              released;
  logic              lock_held;
  logic [NUM_CMD-1:0] cmd_n;

  assign req_kind = '{space: space_e'(req_space), write: req_write};

  mbc_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .bus_release(bus_release),
    .lock_held(lock_held), .bus_ready(bus_ready), .req_ready(req_ready),
    .accept(accept), .addr_stb(addr_stb), .xfer_n(xfer_n), .done(done),
    .released(released)
  );

  mbc_addr_latch #(.BUS_W(BUS_W), .ALIGN_BITS(ALIGN_BITS)) u_lat (
    .clk(clk), .rst_n(rst_n), .accept(accept), .addr_stb(addr_stb),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_kind(req_kind),
    .hold_addr(hold_addr), .hold_wdata(hold_wdata), .hold_kind(hold_kind),
    .lat_addr(lat_addr)
  );

  mbc_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .active(!xfer_n), .kind(hold_kind), .cmd_n(cmd_n)
  );

  assign lmem_rd_n = cmd_n[0];
  assign lmem_wr_n = cmd_n[1];
  assign mem_rd_n  = cmd_n[2];
  assign mem_wr_n  = cmd_n[3];
  assign io_rd_n   = cmd_n[4];
  assign io_wr_n   = cmd_n[5];
  assign xr_rd_n   = cmd_n[6];
  assign xr_wr_n   = cmd_n[7];

  assign ad_out = addr_stb ? hold_addr : hold_wdata;
  assign ad_oe  = addr_stb || (!xfer_n && hold_kind.write);
  assign drv_en = !released;

  // atomic pair tracking for locked memory
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_held <= 1'b0;
    else if (done && (hold_kind.space == SP_LMEM)) lock_held <= !hold_kind.write;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= done;
      if (done && !hold_kind.write) rsp_rdata <= ad_in;
    end
  end

  // R7
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R11
  released_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> (!addr_stb && xfer_n && !ad_oe));
  // R12
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_held && drv_en) |=> drv_en);
endmodule

// File: tb/sim_mbc_top.sv
module sim_mbc_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_space = 2'b00;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [15:0] ad_in = '0;
  logic        addr_stb;
  logic        xfer_n;
  logic        bus_ready = 1'b0;
  logic [15:0] lat_addr;
  logic        bus_release = 1'b0;
  logic        drv_en;
  logic        lmem_rd_n, lmem_wr_n, mem_rd_n, mem_wr_n;
  logic        io_rd_n, io_wr_n, xr_rd_n, xr_wr_n;
  logic [7:0]  cmds;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmds = {xr_wr_n, xr_rd_n, io_wr_n, io_rd_n, mem_wr_n, mem_rd_n, lmem_wr_n, lmem_rd_n};

  mbc_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_space(req_space), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .addr_stb(addr_stb),
    .xfer_n(xfer_n), .bus_ready(bus_ready), .lat_addr(lat_addr),
    .bus_release(bus_release), .drv_en(drv_en),
    .lmem_rd_n(lmem_rd_n), .lmem_wr_n(lmem_wr_n), .mem_rd_n(mem_rd_n),
    .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .xr_rd_n(xr_rd_n), .xr_wr_n(xr_wr_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // edge then settle: drive at +1, sample at +3
  task automatic tick_drive();
    @(posedge clk); #1;
  endtask

  task automatic do_cycle(input logic [1:0] sp, input logic wr, input logic [15:0] a,
                          input logic [15:0] wd, input logic [15:0] rd, input int waits);
    logic [7:0] exp_cmd;
    exp_cmd = ~(8'b1 << {sp, wr});
    tick_drive();
    req_valid = 1'b1; req_space = sp; req_write = wr; req_addr = a;
    req_wdata = wd; ad_in = rd; bus_ready = (waits == 0);
    #2;
    chk(req_ready == 1'b1, "R10", "ready while idle", 32'(req_ready), 32'd1);
    tick_drive();
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~wd;
    #2;
    chk(addr_stb == 1'b1 && ad_oe == 1'b1 && xfer_n == 1'b1, "R2", "address phase ctl",
        {29'd0, addr_stb, ad_oe, xfer_n}, 32'd7);
    chk(ad_out == a, "R2", "address on lines", 32'(ad_out), 32'(a));
    chk(req_ready == 1'b0, "R10", "not ready in address phase", 32'(req_ready), 32'd0);
    chk(cmds == 8'hFF, "R9", "no strobe in address phase", 32'(cmds), 32'hFF);
    tick_drive(); #2;
    chk(xfer_n == 1'b0 && addr_stb == 1'b0, "R4", "transfer line low",
        {30'd0, xfer_n, addr_stb}, 32'd0);
    chk(lat_addr == (a & 16'hFFFE), "R3", "latched aligned address", 32'(lat_addr),
        32'(a & 16'hFFFE));
    chk(ad_oe == wr, "R4", "line direction", 32'(ad_oe), 32'(wr));
    if (wr) chk(ad_out == wd, "R4", "write data on lines", 32'(ad_out), 32'(wd));
    chk(cmds == exp_cmd, "R8", "strobe select", 32'(cmds), 32'(exp_cmd));
    for (int j = 0; j <= waits; j++) begin
      tick_drive();
      if (j == waits) bus_ready = 1'b1;
      #2;
      chk(xfer_n == 1'b0, (waits == 0) ? "R5" : "R6", "held low", 32'(j), 32'(waits));
      chk(cmds == exp_cmd, "R9", "strobe held", 32'(cmds), 32'(exp_cmd));
      chk(req_ready == 1'b0, "R10", "not ready while busy", 32'(req_ready), 32'd0);
    end
    tick_drive(); #2;
    chk(xfer_n == 1'b1, (waits == 0) ? "R5" : "R6", "transfer ended", 32'(xfer_n), 32'd1);
    chk(cmds == 8'hFF, "R9", "strobes off after end", 32'(cmds), 32'hFF);
    chk(rsp_valid == 1'b1, "R7", "response pulse", 32'(rsp_valid), 32'd1);
    if (!wr) chk(rsp_rdata == rd, "R7", "read data", 32'(rsp_rdata), 32'(rd));
    chk(lat_addr == (a & 16'hFFFE), "R3", "latch holds", 32'(lat_addr), 32'(a & 16'hFFFE));
    tick_drive(); #2;
    chk(rsp_valid == 1'b0, "R7", "pulse is one cycle", 32'(rsp_valid), 32'd0);
  endtask

  task automatic test_reset();
    #2;
    chk(xfer_n == 1'b1 && addr_stb == 1'b0 && ad_oe == 1'b0, "R1", "bus idle",
        {29'd0, xfer_n, addr_stb, ad_oe}, 32'd4);
    chk(cmds == 8'hFF, "R1", "strobes off", 32'(cmds), 32'hFF);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1 && drv_en == 1'b1, "R1", "handshake",
        {29'd0, rsp_valid, req_ready, drv_en}, 32'd3);
  endtask

  task automatic test_release_collision();
    tick_drive();
    bus_release = 1'b1; req_valid = 1'b1; req_space = 2'b01; req_write = 1'b0;
    #2;
    chk(req_ready == 1'b0, "R11", "release beats request", 32'(req_ready), 32'd0);
    for (int k = 0; k < 3; k++) begin
      tick_drive(); #2;
      chk(drv_en == 1'b0 && addr_stb == 1'b0, "R11", "released and quiet",
          {30'd0, drv_en, addr_stb}, 32'd0);
    end
    tick_drive();
    bus_release = 1'b0; req_valid = 1'b0;
    tick_drive(); #2;
    chk(drv_en == 1'b1 && req_ready == 1'b1, "R11", "bus regained",
        {30'd0, drv_en, req_ready}, 32'd3);
    do_cycle(2'b01, 1'b0, 16'h2468, 16'h0, 16'h1357, 0);
  endtask

  task automatic test_locked_pair();
    do_cycle(2'b00, 1'b0, 16'h8001, 16'h0, 16'h00F0, 1);
    tick_drive();
    bus_release = 1'b1;
    #2;
    chk(req_ready == 1'b1, "R12", "lock refuses release", 32'(req_ready), 32'd1);
    tick_drive(); #2;
    chk(drv_en == 1'b1, "R12", "drivers kept under lock", 32'(drv_en), 32'd1);
    do_cycle(2'b00, 1'b1, 16'h8001, 16'h00F1, 16'h0, 0);
    #1;
    chk(drv_en == 1'b0 && req_ready == 1'b0, "R12", "release after locked write",
        {30'd0, drv_en, req_ready}, 32'd0);
    tick_drive();
    bus_release = 1'b0;
    tick_drive(); #2;
    chk(drv_en == 1'b1, "R12", "bus regained", 32'(drv_en), 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    test_reset();
    // R2 R3 R4 R5 R7 R8: every space and direction, no waits
    do_cycle(2'b01, 1'b0, 16'h1235, 16'h0000, 16'hBEEF, 0);
    do_cycle(2'b01, 1'b1, 16'h4000, 16'hA5A5, 16'h0000, 0);
    do_cycle(2'b10, 1'b0, 16'h0031, 16'h0000, 16'h0C3C, 0);
    do_cycle(2'b10, 1'b1, 16'h0030, 16'h5A5A, 16'h0000, 0);
    do_cycle(2'b11, 1'b0, 16'h00FF, 16'h0000, 16'h003D, 0);
    do_cycle(2'b11, 1'b1, 16'h00FE, 16'h0021, 16'h0000, 0);
    // R6: wait states
    do_cycle(2'b01, 1'b0, 16'hFFFF, 16'h0000, 16'h7E81, 1);
    do_cycle(2'b01, 1'b1, 16'h8002, 16'h1111, 16'h0000, 3);
    test_release_collision();
    test_locked_pair();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule